// File: doc/BRIEF.md
# Fixed-Length Hit Packet Serializer

This block sits at the output of one readout chip in a silicon strip front end. For each event, upstream logic hands it one word at a time: a chip identifier, a packet kind, a bunch-crossing number, a trigger number and up to two 14-bit hit words, plus a count of how many hit words are valid. The block protects the 20-bit header with a 7-bit code and builds a 55-bit packet. It then shifts the packet out one bit per clock, with a valid strobe and a last-bit marker. The packet has no start or stop bits.

The code is a Hamming code over the header. It can correct a single flipped bit and detect a double flip. A hit-data event with no hits produces no packet at all, so chips with nothing to report leave the shared output quiet.

The input is a valid/ready stream. `in_ready` is high whenever no packet is being shifted out. A word is taken on any clock edge where both `in_valid` and `in_ready` are high. While a packet is in flight, `in_ready` stays low and the upstream must hold its word. The serial output has no back-pressure: once it starts, a packet runs for 55 consecutive cycles.

Top module: `pf_formatter`

## Requirements
- R1: A packet is 55 bits sent most significant first, one per clock, with `out_valid` high on 55 consecutive cycles starting on the cycle after the accepting edge. The order is 5-bit chip ID, 3-bit kind, 8-bit bunch-crossing number, 4-bit trigger number, 7-bit code and 28-bit payload.
- R2: `in_ready` is high exactly when no packet is in flight, including the cycle right after the last bit. A word offered while `in_ready` is low is not taken and causes no extra output.
- R3: Code bits 6..2 are Hamming check bits c4..c0. Codeword positions 1 to 25 reserve the powers of two for checks. The header bits, MSB first, fill the other positions in rising order starting at 3. Check ci is the XOR of the header bits at positions whose bit i is set.
- R4: Code bit 1 is the XOR of all 20 header bits and the five check bits, and code bit 0 is always 0.
- R5: A word of kind 0 (hit data) with a hit count of 0 is accepted, but no packet is sent: `out_valid` stays low and `in_ready` stays high.
- R6: For kind 0 with a count of 1, the payload is the first hit word (`in_hits[27:14]`) followed by the filler 14'h3FFF.
- R7: For kind 0 with a count of 2 or 3, the payload is `in_hits[27:14]` followed by `in_hits[13:0]`.
- R8: For any kind other than 0, a packet is always sent and the payload is `in_hits` unchanged, whatever the count.
- R9: `out_last` is high only on the 55th bit of a packet.
- R10: While reset is held, and right after it, `out_valid` and `out_last` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Event word offered |
| in_ready | output | 1 | Event word can be taken |
| in_chip | input | 5 | Chip identifier |
| in_kind | input | 3 | Packet kind, 0 = hit data |
| in_bcid | input | 8 | Bunch-crossing number |
| in_l1id | input | 4 | Trigger number |
| in_nhit | input | 2 | Number of valid hit words |
| in_hits | input | 28 | Hit slot 0 in the upper 14 bits, slot 1 in the lower 14 bits |
| out_valid | output | 1 | Serial bit valid |
| out_bit | output | 1 | Serial data, MSB first |
| out_last | output | 1 | Final bit of a packet |

## Verification
The bench uses the default widths: 5-bit chip ID, 3-bit kind, 8+4 bit sub-header, 5 check bits and two 14-bit hit slots. These are the only values for which the 55-bit frame and the 25-position codeword are full. With them, the header patterns reach every check bit and the overall parity bit, including the all-zeros header, the all-ones header and chip number 19. The two-slot payload covers the filler, the suppressed empty event, the count of 3, and a held `in_valid` that has to wait out a full packet.

// File: rtl/pf_pkg.sv
package pf_pkg;
  typedef enum logic [2:0] {
    KIND_HIT  = 3'd0,
    KIND_REG  = 3'd1,
    KIND_MON  = 3'd2,
    KIND_TEST = 3'd3
  } pkt_kind_e;
endpackage

// File: rtl/pf_hdr_code.sv
module pf_hdr_code #(
  parameter int HDR_W = 20,
  parameter int CHK_W = 5,
  localparam int CODE_W = CHK_W + 2,
  localparam int CW_LEN = HDR_W + CHK_W
) (
  input  logic [HDR_W-1:0]  hdr,
  output logic [CODE_W-1:0] code
);
  logic [CHK_W-1:0] chk;

  always_comb begin
    int k;
    chk = '0;
    k = HDR_W - 1;
    for (int p = 3; p <= CW_LEN; p++) begin
      if ((p & (p - 1)) != 0 && k >= 0) begin
        for (int j = 0; j < CHK_W; j++) begin
          if (p[j]) chk[j] = chk[j] ^ hdr[k];
        end
        k = k - 1;
      end
    end
  end

  assign code = {chk, (^hdr) ^ (^chk), 1'b0};
endmodule

// File: rtl/pf_payload.sv
module pf_payload #(
  parameter int HIT_W = 14,
  parameter int NHIT  = 2,
  localparam int CNT_W = $clog2(NHIT + 1),
  localparam int PAY_W = HIT_W * NHIT
) (
  input  logic             kind_is_hit,
  input  logic [CNT_W-1:0] nhit,
  input  logic [PAY_W-1:0] hits,
  output logic [PAY_W-1:0] pay
);
  for (genvar i = 0; i < NHIT; i++) begin : g_slot
    localparam int TOP = (NHIT - i) * HIT_W - 1;
    logic used;
    assign used = !kind_is_hit || (nhit > CNT_W'(i));
    assign pay[TOP -: HIT_W] = used ? hits[TOP -: HIT_W] : {HIT_W{1'b1}};
  end
endmodule

// File: rtl/pf_shifter.sv
module pf_shifter #(
  parameter int PKT_W = 55,
  localparam int CNT_W = $clog2(PKT_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PKT_W-1:0] pkt,
  output logic             out_valid,
  output logic             out_bit,
  output logic             out_last
);
  logic [PKT_W-1:0] sreg;
  logic [CNT_W-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0;
      left <= '0;
    end else if (load) begin
      sreg <= pkt;
      left <= CNT_W'(PKT_W);
    end else if (left != '0) begin
      sreg <= {sreg[PKT_W-2:0], 1'b0};
      left <= left - 1'b1;
    end
  end

  assign out_valid = (left != '0);
  assign out_bit   = sreg[PKT_W-1];
  assign out_last  = (left == CNT_W'(1));

  // R1
  run_unbroken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_last |=> out_valid);
endmodule

// File: rtl/pf_formatter.sv
module pf_formatter #(
  parameter int CHIP_W = 5,
  parameter int KIND_W = 3,
  parameter int BCID_W = 8,
  parameter int L1ID_W = 4,
  parameter int CHK_W  = 5,
  parameter int HIT_W  = 14,
  parameter int NHIT   = 2,
  localparam int HDR_W  = CHIP_W + KIND_W + BCID_W + L1ID_W,
  localparam int CODE_W = CHK_W + 2,
  localparam int PAY_W  = HIT_W * NHIT,
  localparam int PKT_W  = HDR_W + CODE_W + PAY_W,
  localparam int CNT_W  = $clog2(NHIT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CHIP_W-1:0] in_chip,
  input  logic [KIND_W-1:0] in_kind,
  input  logic [BCID_W-1:0] in_bcid,
  input  logic [L1ID_W-1:0] in_l1id,
  input  logic [CNT_W-1:0]  in_nhit,
  input  logic [PAY_W-1:0]  in_hits,
  output logic              out_valid,
  output logic              out_bit,
  output logic              out_last
);
  import pf_pkg::*;

  logic [HDR_W-1:0]  hdr;
  logic [CODE_W-1:0] code;
  logic [PAY_W-1:0]  pay;
  logic              kind_is_hit, take, empty_evt, load;

  assign hdr         = {in_chip, in_kind, in_bcid, in_l1id};
  assign kind_is_hit = (in_kind == KIND_W'(KIND_HIT));
  assign take        = in_valid && in_ready;
  assign empty_evt   = kind_is_hit && (in_nhit == '0);
  assign load        = take && !empty_evt;
  assign in_ready    = !out_valid;

  pf_hdr_code #(.HDR_W(HDR_W), .CHK_W(CHK_W)) u_code (
    .hdr  (hdr),
    .code (code)
  );

  pf_payload #(.HIT_W(HIT_W), .NHIT(NHIT)) u_pay (
    .kind_is_hit (kind_is_hit),
    .nhit        (in_nhit),
    .hits        (in_hits),
    .pay         (pay)
  );

  pf_shifter #(.PKT_W(PKT_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .pkt       ({hdr, code, pay}),
    .out_valid (out_valid),
    .out_bit   (out_bit),
    .out_last  (out_last)
  );

  // R2
  start_needs_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid));
  // R4
  code_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> ($countones({hdr, code}) % 2 == 0) && !code[0]);
  // R5
  empty_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && empty_evt |=> !out_valid && in_ready);
  // R6
  filler_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load && kind_is_hit && in_nhit == CNT_W'(1) |-> pay[HIT_W-1:0] == {HIT_W{1'b1}});
  // R9
  last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> !out_valid);
endmodule

// File: tb/test_pf_formatter.sv
module test_pf_formatter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [4:0] in_chip = '0;
  logic [2:0] in_kind = '0;
  logic [7:0] in_bcid = '0;
  logic [3:0] in_l1id = '0;
  logic [1:0] in_nhit = '0;
  logic [27:0] in_hits = '0;
  logic out_valid, out_bit, out_last;

  int total = 0;
  int bad = 0;
  bit exp_q[$];
  string tag_q[$];
  string idle_tag = "R10";

  always #4 clk = ~clk;

  pf_formatter i_pf_formatter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_chip(in_chip), .in_kind(in_kind), .in_bcid(in_bcid), .in_l1id(in_l1id),
    .in_nhit(in_nhit), .in_hits(in_hits),
    .out_valid(out_valid), .out_bit(out_bit), .out_last(out_last)
  );

  task automatic check(string req, logic act, logic exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  // R3 R4: syndrome-style reference code
  function automatic logic [6:0] ref_code(logic [19:0] h);
    logic [4:0] c = '0;
    int k = 19;
    for (int pos = 1; pos <= 25; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        if (h[k]) c = c ^ 5'(pos);
        k--;
      end
    end
    return {c, (^h) ^ (^c), 1'b0};
  endfunction

  task automatic push_packet();
    logic [19:0] h;
    logic [27:0] p;
    logic [54:0] pkt;
    string ptag;
    h = {in_chip, in_kind, in_bcid, in_l1id};
    if (in_kind != 3'd0) begin
      p = in_hits; ptag = "R8";
    end else begin
      p[27:14] = (in_nhit >= 1) ? in_hits[27:14] : 14'h3FFF;
      p[13:0]  = (in_nhit >= 2) ? in_hits[13:0] : 14'h3FFF;
      ptag = (in_nhit == 1) ? "R6" : "R7";
    end
    pkt = {h, ref_code(h), p};
    for (int i = 54; i >= 0; i--) begin
      exp_q.push_back(pkt[i]);
      if (i >= 35) tag_q.push_back("R1");
      else if (i >= 30) tag_q.push_back("R3");
      else if (i >= 28) tag_q.push_back("R4");
      else tag_q.push_back(ptag);
    end
  endtask

  // reference model, compared on every clock
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      string t;
      bit b;
      t = tag_q.pop_front();
      b = exp_q.pop_front();
      check("R1", out_valid, 1'b1, "out_valid");
      check(t, out_bit, b, "out_bit");
      check("R9", out_last, exp_q.size() == 0, "out_last");
      check("R2", in_ready, 1'b0, "in_ready busy");
    end else begin
      check(idle_tag, out_valid, 1'b0, "out_valid idle");
      check("R9", out_last, 1'b0, "out_last idle");
      check(idle_tag, in_ready, 1'b1, "in_ready idle");
    end
    if (rst_n && in_valid && in_ready) begin
      if (in_kind == 3'd0 && in_nhit == 2'd0) idle_tag = "R5";
      else begin
        push_packet();
        idle_tag = "R2";
      end
    end
  end

  task automatic offer(logic [4:0] chip, logic [2:0] kind, logic [7:0] bcid,
                       logic [3:0] l1id, logic [1:0] n, logic [27:0] hits);
    bit r;
    in_chip = chip; in_kind = kind; in_bcid = bcid; in_l1id = l1id;
    in_nhit = n; in_hits = hits; in_valid = 1'b1;
    forever begin
      r = in_ready;
      @(posedge clk); #1;
      if (r) break;
    end
    in_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(2);
    offer(5'd3, 3'd0, 8'hA5, 4'h6, 2'd2, {14'h1234, 14'h0ABC});   // R7
    idle(60);
    offer(5'd19, 3'd0, 8'h01, 4'hF, 2'd1, {14'h2BCD, 14'h0001});  // R6
    idle(60);
    offer(5'd7, 3'd0, 8'h44, 4'h2, 2'd0, 28'h0FFFFFF);            // R5
    idle(5);
    offer(5'd0, 3'd1, 8'h00, 4'h0, 2'd0, 28'h8000001);            // R8
    // back-to-back: held offer waits out the packet (R2)
    offer(5'd31, 3'd7, 8'hFF, 4'hF, 2'd3, 28'hFFFFFFF);
    offer(5'd12, 3'd0, 8'h80, 4'h1, 2'd3, {14'h0000, 14'h3FFE}); // R7 count 3
    idle(60);
    offer(5'd0, 3'd0, 8'h00, 4'h0, 2'd2, 28'h0000000);
    idle(60);
    offer(5'd21, 3'd5, 8'h5A, 4'h9, 2'd2, 28'h5555AAA);
    idle(60);
    offer(5'd1, 3'd0, 8'h00, 4'h0, 2'd0, 28'h0);                  // R5 again
    idle(4);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule